// File: doc/BRIEF.md
# Board Interrupt Aggregator and Register File

This block sits behind a simple synchronous register bus on a board-control device. It collects a vector of external interrupt inputs into one parent interrupt line and keeps a small file of general-purpose 32-bit registers for LED data, LED control, a switch word, three miscellaneous write words, a miscellaneous read word and two card-slot words. The host bus bridge presents only the offset bits within the block's 1 MiB window.

Every clock edge compares the inputs with their previous sample. When an input changes and its enable bit is set, the status register is overwritten with a one-hot code for that source. The parent line then copies the new level of that input. A write to the enable register also redrives the per-source output vector. The new vector is the internal level record XORed with the status register, and the result is written back as the level record. The enable and status registers keep only the bits selected by the constant 0x000FEEFF, so sources 8 and 12 can never be enabled.

Top module: `brd_irq_regs`

## Requirements
- R1: While `rst` is high at a clock edge, every register, the level record and `src_level` clear, and `irq_parent` goes low. Every mapped offset then reads 0.
- R2: The plain registers hold full 32-bit values. A write takes effect at the clock edge. Reads are combinational. The offsets are 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88, 0x90, 0xE0 and 0xE4, and the miscellaneous read word at 0x90 is also writable.
- R3: The enable register (0xC0) and the status register (0xD0) store write data ANDed with 0x000FEEFF. They read back in the same form.
- R4: Suppose input i differs from its value at the previous edge and enable bit i is set. At that edge the status register becomes 1<<i and `irq_parent` takes the new level of input i.
- R5: A change on an input whose enable bit is clear updates only the level record. The status register and `irq_parent` are unchanged.
- R6: A write to 0xC0 computes the level record XOR the status register, both taken before the edge. `src_level` takes the low bits of that value, and the value, with any same-edge input changes applied, becomes the level record. `src_level` changes at no other time except reset.
- R7: A read from any unmapped offset returns 0. A write to an unmapped offset changes no register.
- R8: `bus_addr` carries the 20 offset bits, and all 20 are compared, so for example 0x10010 does not alias 0x10.
- R9: When several enabled inputs change at the same edge, the lowest-numbered one sets the status register and `irq_parent`.
- R10: An enabled input change beats a bus write to the status register at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 20 | Byte offset within the window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq_in | input | 16 | External interrupt levels |
| irq_parent | output | 1 | Aggregated parent interrupt |
| src_level | output | 16 | Per-source level outputs |

## Verification
The bench builds the block with its default parameters: 16 sources, 32-bit data and a 20-bit offset. At that size a single 16-bit input vector can toggle several sources in one cycle, including the never-enabled sources 8 and 12. That brings the lowest-index priority and the status-versus-event race within reach. With the full 20-bit offset, accesses just above the register map, such as 0x10010, fall on unmapped locations and exercise the no-alias rule.

// File: rtl/brd_irq_pkg.sv
package brd_irq_pkg;

    // Bits the enable and status registers are allowed to hold
    localparam logic [31:0] IRQ_KEEP = 32'h000F_EEFF;

    // Number of plain storage registers
    localparam int unsigned N_PLAIN = 10;

    // Register selects; plain registers come first so the enum value indexes the bank
    typedef enum logic [3:0] {
        SEL_LED0   = 4'd0,
        SEL_LED1   = 4'd1,
        SEL_LEDCTL = 4'd2,
        SEL_SW     = 4'd3,
        SEL_MW0    = 4'd4,
        SEL_MW1    = 4'd5,
        SEL_MW2    = 4'd6,
        SEL_MR     = 4'd7,
        SEL_SLOT0  = 4'd8,
        SEL_SLOT1  = 4'd9,
        SEL_IEN    = 4'd10,
        SEL_ISTAT  = 4'd11,
        SEL_NONE   = 4'd12
    } reg_sel_e;

    localparam int unsigned N_MAPPED = 12;

    function automatic logic [31:0] sel_offset(input int unsigned k);
        logic [31:0] off;
        unique case (k)
            0:       off = 32'h10;
            1:       off = 32'h14;
            2:       off = 32'h40;
            3:       off = 32'h60;
            4:       off = 32'h80;
            5:       off = 32'h84;
            6:       off = 32'h88;
            7:       off = 32'h90;
            8:       off = 32'hE0;
            9:       off = 32'hE4;
            10:      off = 32'hC0;
            11:      off = 32'hD0;
            default: off = 32'hFFFF_FFFF;
        endcase
        return off;
    endfunction

endpackage

// File: rtl/brd_reg_decode.sv
module brd_reg_decode
    import brd_irq_pkg::*;
#(
    parameter int unsigned OFS_W = 20
) (
    input  logic [OFS_W-1:0] addr,
    output reg_sel_e         sel
);
    always_comb begin
        sel = SEL_NONE;
        for (int unsigned k = 0; k < N_MAPPED; k++) begin
            if (addr == sel_offset(k)[OFS_W-1:0]) begin
                sel = reg_sel_e'(k[3:0]);
            end
        end
    end
endmodule

// File: rtl/brd_gp_bank.sv
module brd_gp_bank #(
    parameter int unsigned DW = 32,
    parameter int unsigned N  = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         we_vec,
    input  logic [DW-1:0]        wdata,
    output logic [N-1:0][DW-1:0] q
);
    for (genvar g = 0; g < N; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                q[g] <= '0;
            end else if (we_vec[g]) begin
                q[g] <= wdata;
            end
        end
    end
endmodule

// File: rtl/brd_irq_core.sv
module brd_irq_core
    import brd_irq_pkg::*;
#(
    parameter int unsigned N_SRC = 16,
    parameter int unsigned DW    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] irq_in,
    input  logic             ien_we,
    input  logic             stat_we,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    ien_q,
    output logic [DW-1:0]    stat_q,
    output logic             irq_parent,
    output logic [N_SRC-1:0] src_level,
    output logic             ev_any
);
    localparam int unsigned IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam logic [DW-1:0] KEEP_W = DW'(IRQ_KEEP);

    logic [N_SRC-1:0] in_prev;
    logic [N_SRC-1:0] chg;
    logic [N_SRC-1:0] ev;
    logic [DW-1:0]    lvl_q;
    logic [DW-1:0]    lvl_x;
    logic [DW-1:0]    lvl_d;
    logic [DW-1:0]    chg_w;
    logic [DW-1:0]    irq_w;
    logic [IW-1:0]    win;
    logic             found;

    assign chg    = irq_in ^ in_prev;
    assign ev     = chg & ien_q[N_SRC-1:0];
    assign ev_any = |ev;
    assign chg_w  = DW'(chg);
    assign irq_w  = DW'(irq_in);

    // Lowest-numbered enabled change wins
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (ev[i] && !found) begin
                found = 1'b1;
                win   = IW'(i);
            end
        end
    end

    // Mask write folds status into the level record, then input changes apply
    assign lvl_x = ien_we ? (lvl_q ^ stat_q) : lvl_q;
    assign lvl_d = (lvl_x & ~chg_w) | (irq_w & chg_w);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_prev    <= '0;
            lvl_q      <= '0;
            ien_q      <= '0;
            stat_q     <= '0;
            irq_parent <= 1'b0;
            src_level  <= '0;
        end else begin
            in_prev <= irq_in;
            lvl_q   <= lvl_d;
            if (ien_we) begin
                ien_q     <= wdata & KEEP_W;
                src_level <= lvl_x[N_SRC-1:0];
            end
            if (ev_any) begin
                stat_q     <= DW'(1) << win;
                irq_parent <= irq_in[win];
            end else if (stat_we) begin
                stat_q <= wdata & KEEP_W;
            end
        end
    end
endmodule

// File: rtl/brd_irq_regs.sv
module brd_irq_regs
    import brd_irq_pkg::*;
#(
    parameter int unsigned N_SRC = 16,
    parameter int unsigned DW    = 32,
    parameter int unsigned OFS_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OFS_W-1:0] bus_addr,
    input  logic             bus_we,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [N_SRC-1:0] irq_in,
    output logic             irq_parent,
    output logic [N_SRC-1:0] src_level
);
    reg_sel_e                     dec_sel;
    logic [N_PLAIN-1:0]           gp_we;
    logic [N_PLAIN-1:0][DW-1:0]   gp_q;
    logic [DW-1:0]                ien_q;
    logic [DW-1:0]                stat_q;
    logic                         ev_any;
    logic                         ien_we;
    logic                         stat_we;

    brd_reg_decode #(.OFS_W(OFS_W)) u_dec (
        .addr (bus_addr),
        .sel  (dec_sel)
    );

    for (genvar g = 0; g < N_PLAIN; g++) begin : g_we
        assign gp_we[g] = bus_we && (dec_sel == reg_sel_e'(g));
    end

    assign ien_we  = bus_we && (dec_sel == SEL_IEN);
    assign stat_we = bus_we && (dec_sel == SEL_ISTAT);

    brd_gp_bank #(.DW(DW), .N(N_PLAIN)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .we_vec (gp_we),
        .wdata  (bus_wdata),
        .q      (gp_q)
    );

    brd_irq_core #(.N_SRC(N_SRC), .DW(DW)) u_core (
        .clk        (clk),
        .rst        (rst),
        .irq_in     (irq_in),
        .ien_we     (ien_we),
        .stat_we    (stat_we),
        .wdata      (bus_wdata),
        .ien_q      (ien_q),
        .stat_q     (stat_q),
        .irq_parent (irq_parent),
        .src_level  (src_level),
        .ev_any     (ev_any)
    );

    always_comb begin
        unique case (dec_sel)
            SEL_LED0, SEL_LED1, SEL_LEDCTL, SEL_SW, SEL_MW0,
            SEL_MW1, SEL_MW2, SEL_MR, SEL_SLOT0, SEL_SLOT1:
                bus_rdata = gp_q[dec_sel];
            SEL_IEN:   bus_rdata = ien_q;
            SEL_ISTAT: bus_rdata = stat_q;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/brd_irq_regs_chk.sv
module brd_irq_regs_chk
    import brd_irq_pkg::*;
#(
    parameter int unsigned N_SRC = 16,
    parameter int unsigned DW    = 32
) (
    input logic             clk,
    input logic             rst,
    input reg_sel_e         sel,
    input logic             bus_we,
    input logic [DW-1:0]    bus_rdata,
    input logic [DW-1:0]    ien,
    input logic [DW-1:0]    stat,
    input logic             irq_parent,
    input logic [N_SRC-1:0] src_level,
    input logic             ev_any
);
    localparam logic [DW-1:0] KEEP_W = DW'(IRQ_KEEP);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (stat == '0 && ien == '0 && !irq_parent && src_level == '0)); // R1

    AST_KEEP_BITS: assert property (@(posedge clk) disable iff (rst)
        ((ien | stat) & ~KEEP_W) == '0); // R3

    AST_EVENT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        ev_any |=> $countones(stat) == 1); // R4

    AST_QUIET_PARENT: assert property (@(posedge clk) disable iff (rst)
        !ev_any |=> $stable(irq_parent)); // R5

    AST_SRC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && sel == SEL_IEN) |=> $stable(src_level)); // R6

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE) |-> bus_rdata == '0); // R7
endmodule

bind brd_irq_regs brd_irq_regs_chk #(.N_SRC(N_SRC), .DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sel        (dec_sel),
    .bus_we     (bus_we),
    .bus_rdata  (bus_rdata),
    .ien        (ien_q),
    .stat       (stat_q),
    .irq_parent (irq_parent),
    .src_level  (src_level),
    .ev_any     (ev_any)
);

// File: tb/brd_irq_regs_test.sv
`timescale 1ns/1ps
module brd_irq_regs_test;
    localparam logic [31:0] KEEP = 32'h000F_EEFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_in = '0;
    logic        irq_parent;
    logic [15:0] src_level;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench model
    logic [31:0] m_gp [10];
    logic [31:0] m_ien, m_stat, m_lvl;
    logic [15:0] m_prev, m_src;
    logic        m_parent;

    always #2.5 clk = ~clk;

    brd_irq_regs uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .irq_parent(irq_parent), .src_level(src_level)
    );

    function automatic int m_sel(input logic [19:0] a);
        case (a)
            20'h10: return 0;  20'h14: return 1;  20'h40: return 2;
            20'h60: return 3;  20'h80: return 4;  20'h84: return 5;
            20'h88: return 6;  20'h90: return 7;  20'hE0: return 8;
            20'hE4: return 9;  20'hC0: return 10; 20'hD0: return 11;
            default: return 12;
        endcase
    endfunction

    function automatic logic [31:0] m_read(input logic [19:0] a);
        int s = m_sel(a);
        if (s < 10)  return m_gp[s];
        if (s == 10) return m_ien;
        if (s == 11) return m_stat;
        return 32'h0;
    endfunction

    function automatic logic [19:0] map_addr(input int k);
        case (k)
            0: return 20'h10; 1: return 20'h14; 2: return 20'h40; 3: return 20'h60;
            4: return 20'h80; 5: return 20'h84; 6: return 20'h88; 7: return 20'h90;
            8: return 20'hE0; 9: return 20'hE4; 10: return 20'hC0; default: return 20'hD0;
        endcase
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 10; i++) m_gp[i] = '0;
        m_ien = '0; m_stat = '0; m_lvl = '0; m_prev = '0; m_src = '0; m_parent = 1'b0;
    endtask

    // one bus cycle: drive at negedge, check read, model the edge, check outputs
    task automatic cyc(input logic [19:0] a, input logic w, input logic [31:0] d,
                       input logic [15:0] irq, input string tag);
        int s;
        logic [15:0] chg, ev;
        logic [31:0] lx;
        bus_addr = a; bus_we = w; bus_wdata = d; irq_in = irq;
        #1;
        chk(bus_rdata, m_read(a), {tag, " read"});
        s   = m_sel(a);
        chg = irq ^ m_prev;
        ev  = chg & m_ien[15:0];
        lx  = (w && s == 10) ? (m_lvl ^ m_stat) : m_lvl;
        if (w && s == 10) begin
            m_src = lx[15:0];
            m_ien = d & KEEP;
        end
        m_lvl = (lx & ~{16'h0, chg}) | ({16'h0, irq} & {16'h0, chg});
        if (ev != 0) begin
            for (int i = 15; i >= 0; i--) begin
                if (ev[i]) begin
                    m_stat   = 32'h1 << i;
                    m_parent = irq[i];
                end
            end
        end else if (w && s == 11) begin
            m_stat = d & KEEP;
        end
        if (w && s < 10) m_gp[s] = d;
        m_prev = irq;
        @(negedge clk);
        chk({31'h0, irq_parent}, {31'h0, m_parent}, {tag, " parent"});
        chk({16'h0, src_level}, {16'h0, m_src}, {tag, " src_level"});
    endtask

    task automatic rd_all(input string tag);
        for (int k = 0; k < 12; k++) cyc(map_addr(k), 1'b0, 32'h0, irq_in, tag);
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: everything reads zero after reset
        rd_all("R1");

        // R2: plain registers hold full words
        for (int k = 0; k < 10; k++) cyc(map_addr(k), 1'b1, 32'hA5C3_0F00 ^ k, 16'h0, "R2");
        rd_all("R2");

        // R3: reserved bits dropped on enable and status
        cyc(20'hC0, 1'b1, 32'hFFFF_FFFF, 16'h0, "R3");
        cyc(20'hD0, 1'b1, 32'hFFFF_FFFF, 16'h0, "R3");
        cyc(20'hC0, 1'b0, 32'h0, 16'h0, "R3");
        chk(bus_rdata, 32'h000F_EEFF, "R3 enable readback");
        cyc(20'hD0, 1'b0, 32'h0, 16'h0, "R3");
        chk(bus_rdata, 32'h000F_EEFF, "R3 status readback");

        // R7 / R8: unmapped and out-of-map offsets ignored
        cyc(20'h44, 1'b1, 32'hDEAD_BEEF, 16'h0, "R7");
        cyc(20'h10010, 1'b1, 32'h1234_5678, 16'h0, "R8");
        cyc(20'h100D0, 1'b1, 32'h0, 16'h0, "R8");
        cyc(20'h10010, 1'b0, 32'h0, 16'h0, "R8");
        chk(bus_rdata, 32'h0, "R8 no alias read");
        rd_all("R7");

        // R4: enabled event loads one-hot status and parent level
        cyc(20'hD0, 1'b1, 32'h0, 16'h0, "R4");
        cyc(20'h00, 1'b0, 32'h0, 16'h0008, "R4");
        cyc(20'hD0, 1'b0, 32'h0, 16'h0008, "R4");
        chk(bus_rdata, 32'h8, "R4 status one-hot");
        chk({31'h0, irq_parent}, 32'h1, "R4 parent high");
        cyc(20'h00, 1'b0, 32'h0, 16'h0000, "R4");
        chk({31'h0, irq_parent}, 32'h0, "R4 parent low");

        // R5: disabled source (12 never enabled) leaves status and parent
        cyc(20'h00, 1'b0, 32'h0, 16'h1000, "R5");
        cyc(20'hD0, 1'b0, 32'h0, 16'h1000, "R5");
        chk(bus_rdata, 32'h8, "R5 status held");

        // R9: lowest enabled source wins
        cyc(20'h00, 1'b0, 32'h0, 16'h1044, "R9");
        cyc(20'hD0, 1'b0, 32'h0, 16'h1044, "R9");
        chk(bus_rdata, 32'h4, "R9 lowest wins");

        // R10: event beats status write
        cyc(20'hD0, 1'b1, 32'h0000_0300, 16'h1045, "R10");
        cyc(20'hD0, 1'b0, 32'h0, 16'h1045, "R10");
        chk(bus_rdata, 32'h1, "R10 event priority");

        // R6: enable write redrives per-source outputs
        cyc(20'hC0, 1'b1, 32'h0000_00FF, 16'h1045, "R6");
        cyc(20'hC0, 1'b1, 32'h0000_00FF, 16'h1045, "R6");

        // random mix: R2 R4 R5 R6 R7 R9 R10
        for (int n = 0; n < 4000; n++) begin
            logic [19:0] a;
            logic [15:0] irq;
            int r = $urandom_range(0, 15);
            if (r < 12) a = map_addr(r);
            else a = 20'($urandom);
            irq = irq_in;
            if ($urandom_range(0, 3) == 0) irq = irq ^ 16'($urandom) & 16'($urandom);
            cyc(a, $urandom_range(0, 1) == 1, $urandom, irq, "R2/R4/R5/R6/R7/R9/R10 random");
        end

        // R1 again: reset mid-run
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        m_prev = irq_in;
        irq_in = irq_in;
        chk({31'h0, irq_parent}, 32'h0, "R1 parent after reset");
        chk({16'h0, src_level}, 32'h0, "R1 src_level after reset");
        cyc(20'hC0, 1'b0, 32'h0, 16'h0, "R1");
        m_prev = 16'h0;
        rd_all("R1");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule